// File: doc/BRIEF.md
# Local-Bus Interrupt Combiner

This block gathers sixteen level-sensitive interrupt requests from devices on a local bus and merges them into one interrupt line for the processor. Each request is captured in a source register that follows the input level. An enable mask register selects which captured requests may count as pending. The combined output is high while at least one enabled request is pending.

Software reaches the block through a small 16-bit register port. One offset returns an encoded vector that identifies the lowest-numbered pending request, so an interrupt handler can dispatch straight from the value it reads. A second offset holds the enable mask and can be read and written. There are no acknowledge cycles, no edge detection and no nesting. A request stays pending for as long as its input stays high and its enable bit is set.

Top module: `lbi_irq_combiner`

## Requirements
- R1: Source bit k takes the level of request input k on every rising clock edge, so a change on an input reaches the output one clock later and not earlier.
- R2: `irq_o` is high exactly when the bitwise AND of the source bits and the enable mask is non-zero.
- R3: A read at byte offset 0x00 returns 4 × (k + 1), where k is the lowest index of a pending request. It returns 0 when no request is pending.
- R4: A write at byte offset 0x02 loads all 16 mask bits, and `irq_o` reflects the new mask from the next clock on. A read at offset 0x02 returns the mask.
- R5: While reset is active and right after it ends, the mask reads 0x0010, the source bits are all zero, the vector reads 0 and `irq_o` is low, whatever the request inputs do during reset.
- R6: A write at any offset other than 0x02, offset 0x00 included, leaves the mask unchanged. A read at any offset other than 0x00 and 0x02 returns 0.
- R7: Reading the vector offset has no side effect. Repeated reads return the same value and `irq_o` does not change.
- R8: When several requests are pending, the vector always names the lowest-numbered one, whatever higher-numbered bits are also set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lvl_i | input | 16 | Level interrupt requests, bit k is request k |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from reg_addr_i |
| irq_o | output | 1 | Combined interrupt, high while an enabled request is pending |

## Verification
With every mask bit enabled, the main sweep walks all 65,536 request patterns. This shows that the vector always tracks the lowest set bit and is not the highest or a count of bits, and that the output rises for every non-zero pattern. A second sweep holds all requests high and steps the mask through every single-bit value and a pseudo-random series. This separates masking from capture and confirms that a mask write acts on the output one clock later. The remaining checks cover the reset value of the mask, writes and reads at unmapped offsets, the one-clock latency from an input to the output, and repeated vector reads.

// File: rtl/lbi_pkg.sv
package lbi_pkg;

  // Register select produced by the address decoder.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

  // Vector code is (index + 1) scaled by four.
  localparam int unsigned VEC_SHIFT = 2;

endpackage

// File: rtl/lbi_src_capture.sv
module lbi_src_capture #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] src_q
);

  // One flop per request line; each follows its input level.
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[g] <= 1'b0;
      end else begin
        src_q[g] <= lvl_i[g];
      end
    end
  end

endmodule

// File: rtl/lbi_mask_reg.sv
module lbi_mask_reg #(
  parameter int unsigned N       = 16,
  parameter logic [N-1:0] RST_VAL = 16'h0010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= RST_VAL;
    end else if (we_i) begin
      mask_q <= wdata_i;
    end
  end

endmodule

// File: rtl/lbi_prio_enc.sv
module lbi_prio_enc
  import lbi_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned DW = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     pend_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     first_oh_o,
  output logic [DW-1:0]    vec_o
);

  // Scaled vector code for a found index.
  function automatic logic [DW-1:0] vec_code(input logic found,
                                             input logic [IDX_W-1:0] idx);
    logic [DW-1:0] t;
    t = DW'(idx) + DW'(1);
    return found ? (t << VEC_SHIFT) : '0;
  endfunction

  // below[k] is high when any lower-numbered bit is pending.
  logic [N:0] below;
  assign below[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign first_oh_o[g] = pend_i[g] & ~below[g];
    assign below[g+1]    = below[g] | pend_i[g];
  end

  assign hit_o = below[N];

  // One-hot to binary.
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      if (first_oh_o[k]) begin
        idx_o = idx_o | IDX_W'(k);
      end
    end
  end

  assign vec_o = vec_code(hit_o, idx_o);

endmodule

// File: rtl/lbi_reg_decode.sv
module lbi_reg_decode
  import lbi_pkg::*;
#(
  parameter int unsigned   AW       = 12,
  parameter logic [AW-1:0] VEC_OFF  = 12'h000,
  parameter logic [AW-1:0] MASK_OFF = 12'h002
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  output reg_sel_e      sel_o,
  output logic          mask_we_o
);

  always_comb begin
    if (addr_i == VEC_OFF) begin
      sel_o = SEL_VEC;
    end else if (addr_i == MASK_OFF) begin
      sel_o = SEL_MASK;
    end else begin
      sel_o = SEL_NONE;
    end
  end

  // Only the mask offset accepts writes.
  assign mask_we_o = wr_i && (sel_o == SEL_MASK);

endmodule

// File: rtl/lbi_irq_combiner.sv
module lbi_irq_combiner
  import lbi_pkg::*;
#(
  parameter int unsigned    N        = 16,
  parameter int unsigned    DW       = 16,
  parameter int unsigned    AW       = 12,
  parameter logic [N-1:0]   MASK_RST = 16'h0010,
  parameter logic [AW-1:0]  VEC_OFF  = 12'h000,
  parameter logic [AW-1:0]  MASK_OFF = 12'h002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_lvl_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);

  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  // Named internal events, visible to the bound checker.
  logic [N-1:0]     src_q;
  logic [N-1:0]     mask_q;
  logic [N-1:0]     pend;
  logic [N-1:0]     first_oh;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    vec;
  logic             mask_we;
  reg_sel_e         sel;

  lbi_src_capture #(.N(N)) u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (irq_lvl_i),
    .src_q (src_q)
  );

  lbi_reg_decode #(.AW(AW), .VEC_OFF(VEC_OFF), .MASK_OFF(MASK_OFF)) u_dec (
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .sel_o     (sel),
    .mask_we_o (mask_we)
  );

  lbi_mask_reg #(.N(N), .RST_VAL(MASK_RST)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mask_we),
    .wdata_i (reg_wdata_i[N-1:0]),
    .mask_q  (mask_q)
  );

  assign pend = src_q & mask_q;

  lbi_prio_enc #(.N(N), .DW(DW)) u_enc (
    .pend_i     (pend),
    .hit_o      (hit),
    .idx_o      (idx),
    .first_oh_o (first_oh),
    .vec_o      (vec)
  );

  // Output depends on registers only: one clock after any change.
  assign irq_o = |pend;

  always_comb begin
    unique case (sel)
      SEL_VEC:  reg_rdata_o = vec;
      SEL_MASK: reg_rdata_o = DW'(mask_q);
      default:  reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/lbi_irq_combiner_chk.sv
module lbi_irq_combiner_chk #(
  parameter int unsigned   N        = 16,
  parameter int unsigned   DW       = 16,
  parameter int unsigned   AW       = 12,
  parameter logic [AW-1:0] VEC_OFF  = 12'h000,
  parameter logic [AW-1:0] MASK_OFF = 12'h002
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  irq_lvl_i,
  input logic [N-1:0]  src_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  first_oh,
  input logic [DW-1:0] vec,
  input logic          irq_o,
  input logic          reg_wr_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] reg_rdata_o
);

  logic past_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  AST_SRC_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> src_q == $past(irq_lvl_i)); // R1

  AST_IRQ_AGREES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (vec != '0)); // R2

  AST_FIRST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_oh) && ((first_oh != '0) == (pend != '0))); // R8

  AST_FIRST_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    ((first_oh - N'(1)) & pend) == '0); // R8

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == MASK_OFF) |=> mask_q == $past(reg_wdata_i[N-1:0])); // R4

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == MASK_OFF) |=> $stable(mask_q)); // R6

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i != VEC_OFF && reg_addr_i != MASK_OFF) |-> reg_rdata_o == '0); // R6

endmodule

bind lbi_irq_combiner lbi_irq_combiner_chk #(
  .N(N), .DW(DW), .AW(AW), .VEC_OFF(VEC_OFF), .MASK_OFF(MASK_OFF)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_lvl_i   (irq_lvl_i),
  .src_q       (src_q),
  .mask_q      (mask_q),
  .pend        (pend),
  .first_oh    (first_oh),
  .vec         (vec),
  .irq_o       (irq_o),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/lbi_irq_combiner_tb.sv
`timescale 1ns/1ps
module lbi_irq_combiner_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_lvl_i;
  logic        reg_wr_i;
  logic [11:0] reg_addr_i;
  logic [15:0] reg_wdata_i;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lbi_irq_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq_lvl_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  // Expected vector: scan from the top down so the last hit is the lowest.
  function automatic logic [15:0] exp_vec(input logic [15:0] p);
    logic [15:0] r;
    r = 16'd0;
    for (int i = 15; i >= 0; i--) if (p[i]) r = 16'(4 * i + 4);
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Returns at a negedge, with the new mask already in place.
  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_addr_i = 12'h000;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #0.2;
    d = reg_rdata_o;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-reqs act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d, prev_exp, m, lfsr;
    rst_n = 1'b0; reg_wr_i = 1'b0; reg_addr_i = 12'h000; reg_wdata_i = 16'h0;
    irq_lvl_i = 16'hFFFF;

    // R5: reset state, inputs high during reset
    repeat (3) @(negedge clk);
    #1;
    chk("R5 irq in reset", {15'd0, irq_o}, 16'h0);
    rd(12'h000, d); chk("R5 vector in reset", d, 16'h0);
    rd(12'h002, d); chk("R5 mask in reset", d, 16'h0010);
    irq_lvl_i = 16'h0000;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R5 irq after reset", {15'd0, irq_o}, 16'h0);
    rd(12'h002, d); chk("R5 mask after reset", d, 16'h0010);
    rd(12'h000, d); chk("R5 vector after reset", d, 16'h0);

    // R5/R2: default mask enables only request 4
    irq_lvl_i = 16'hFFEF;
    @(negedge clk); #1;
    chk("R2 default mask blocks", {15'd0, irq_o}, 16'h0);
    irq_lvl_i = 16'h0010;
    @(negedge clk); #1;
    chk("R2 default mask passes", {15'd0, irq_o}, 16'h1);
    rd(12'h000, d); chk("R3 default vec", d, 16'd20);

    // R7: repeated vector reads have no side effect
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      rd(12'h000, d); chk("R7 repeat read vec", d, 16'd20);
      chk("R7 irq steady", {15'd0, irq_o}, 16'h1);
    end

    // R6: writes elsewhere ignored, unmapped reads zero
    wr(12'h000, 16'hFFFF);
    rd(12'h002, d); chk("R6 write at 0x00 ignored", d, 16'h0010);
    wr(12'h004, 16'h1234);
    rd(12'h002, d); chk("R6 write at 0x04 ignored", d, 16'h0010);
    wr(12'h003, 16'h0000);
    rd(12'h002, d); chk("R6 write at 0x03 ignored", d, 16'h0010);
    chk("R6 irq unaffected", {15'd0, irq_o}, 16'h1);
    rd(12'h001, d); chk("R6 read 0x01", d, 16'h0);
    rd(12'h004, d); chk("R6 read 0x04", d, 16'h0);
    rd(12'h006, d); chk("R6 read 0x06", d, 16'h0);
    rd(12'hFFE, d); chk("R6 read 0xFFE", d, 16'h0);
    reg_addr_i = 12'h000;

    // R4: mask write and readback
    wr(12'h002, 16'hA5C3);
    rd(12'h002, d); chk("R4 mask readback", d, 16'hA5C3);
    wr(12'h002, 16'hFFFF);
    rd(12'h002, d); chk("R4 mask readback all", d, 16'hFFFF);
    reg_addr_i = 12'h000;

    // R1/R2/R3/R8: all request patterns with every bit enabled
    @(negedge clk);
    prev_exp = 16'(irq_lvl_i != 16'h0);
    for (int p = 0; p < 65536; p++) begin
      #1;
      irq_lvl_i = 16'(p);
      #0.5;
      chk("R1 no change before edge", {15'd0, irq_o}, prev_exp);
      @(negedge clk); #1;
      chk("R2 irq sweep", {15'd0, irq_o}, 16'(p != 0));
      chk("R3 R8 vector sweep", reg_rdata_o, exp_vec(16'(p)));
      prev_exp = 16'(p != 0);
      @(negedge clk);
    end

    // R4: mask sweep with all requests high
    irq_lvl_i = 16'hFFFF;
    for (int k = 0; k <= 16; k++) begin
      m = (k == 16) ? 16'h0000 : (16'h1 << k);
      wr(12'h002, m);
      chk("R4 irq after mask write", {15'd0, irq_o}, 16'(m != 0));
      rd(12'h000, d); chk("R4 vector after mask write", d, exp_vec(m));
    end
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = lfsr;
      irq_lvl_i = {lfsr[7:0], lfsr[15:8]} ^ 16'h3C5A;
      wr(12'h002, m);
      chk("R2 R4 irq mixed", {15'd0, irq_o}, 16'((irq_lvl_i & m) != 0));
      rd(12'h000, d); chk("R3 R8 vec mixed", d, exp_vec(irq_lvl_i & m));
      rd(12'h002, d); chk("R4 mask mixed", d, m);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule